// File: doc/BRIEF.md
# Switching Cycle Clock Source Selector

This block decides which clock paces the cycles of a switching regulator. By default the cycles follow a free-running internal oscillator, which reaches the block as a one-clock tick at a nominal 750 kHz, or about one tick every 1.3 µs. When an external synchronization signal appears on the sync pin, the block locks onto it at the first rising edge. From then on each external rising edge starts a cycle. The expected external rate is 500 kHz to 1 MHz.

If the external clock stops, the block falls back to the internal oscillator on its own. The count of internal ticks seen since the last external edge decides the moment of fallback. The tick that triggers the fallback also starts a cycle, so the cycle pacing has no gap.

While the regulator is in soft-start, the sync pin has no effect and the internal oscillator paces every cycle. The sync pin is asynchronous to the fast system clock. It passes through a synchronizer chain before its edges are detected.

Top module: `clksel_top`

## Requirements
- R1: While `rst_n` is low, `cyc_start` and `ext_active` are both 0.
- R2: With `ext_active` at 0, an `int_tick` sampled high at a clock edge makes `cyc_start` high for exactly one clock after that edge.
- R3: With `soft_start` low, a rising level on `sync_in` sampled at edge k (after a low sample) sets `ext_active` to 1 and pulses `cyc_start` after edge k+2. This latency covers the two synchronizer stages at the default `SYNC_STAGES` of 2.
- R4: With `ext_active` at 1, `int_tick` produces no `cyc_start` until fallback, and each detected external rising edge produces exactly one `cyc_start`.
- R5: With `ext_active` at 1, the `MISS_TICKS`-th `int_tick` (default 2) after the last external edge clears `ext_active` and produces a `cyc_start` in the same clock, so pacing has no gap.
- R6: Every external rising edge resets the missing-edge tick count to zero, so ticks that arrive before and after an edge are not added together.
- R7: While `soft_start` is high, `sync_in` edges produce no `cyc_start` and do not set `ext_active`. Raising `soft_start` while `ext_active` is 1 clears `ext_active` at the next clock. Internal ticks keep pacing cycles during soft-start.
- R8: In internal mode, an `int_tick` and a detected external edge in the same clock produce a single `cyc_start` pulse, not two.
- R9: Holding `sync_in` high counts as one rising edge only. A steady high level does not keep external mode alive, and fallback follows R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_tick | input | 1 | One-clock tick from the internal oscillator |
| sync_in | input | 1 | Raw external synchronization pin, asynchronous |
| soft_start | input | 1 | High while soft-start is in progress |
| cyc_start | output | 1 | One-clock pulse at the start of each switching cycle |
| ext_active | output | 1 | 1 when the external clock paces cycles |

## Verification
The following properties are checked on every clock:
- the quiet outputs during reset;
- the one-clock response to an internal tick in internal mode;
- locking on a detected edge;
- the silence of the external-mode output between edges and ticks;
- the pulse that comes with every fallback;
- the forced return to internal mode under soft-start.

Only the bench scenarios can show the following:
- the exact latency through the synchronizer;
- that the watchdog count restarts at each edge;
- that a held-high sync level counts once;
- that a simultaneous tick and edge yield a single pulse.

The bench shows these by matching every pulse against a precomputed cycle number.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
   typedef enum logic {
      SRC_INT = 1'b0,
      SRC_EXT = 1'b1
   } clk_src_e;
endpackage

// File: rtl/clksel_sync_edge.sv
// Synchronizer chain on an asynchronous pin followed by a rising-edge detector.
module clksel_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("clksel_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         last_q  <= chain_q[TOP];
      end
   end

   assign rise = chain_q[TOP] & ~last_q;
endmodule

// File: rtl/clksel_miss_wdog.sv
// Counts internal ticks since the last external edge; flags the tick that
// completes the allowed gap.
module clksel_miss_wdog #(
   parameter int MISS_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic tick,
   input  logic ext_edge,
   output logic expire
);
   if (MISS_TICKS < 1) begin : g_bad_miss
      $error("clksel_miss_wdog: MISS_TICKS must be at least 1");
   end

   if (MISS_TICKS == 1) begin : g_no_count
      assign expire = arm & tick & ~ext_edge;
   end else begin : g_count
      localparam int CW = $clog2(MISS_TICKS);
      localparam logic [CW-1:0] LAST = CW'(MISS_TICKS - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!arm || ext_edge) begin
            cnt_q <= '0;
         end else if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end

      assign expire = arm & tick & ~ext_edge & (cnt_q == LAST);
   end
endmodule

// File: rtl/clksel_arbiter.sv
// Source selection state and the registered cycle-start pulse.
module clksel_arbiter
   import clksel_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     ext_edge,
   input  logic     soft_start,
   input  logic     expire,
   output clk_src_e src,
   output logic     pulse
);
   clk_src_e src_q, src_d;
   logic     pulse_q, pulse_d;
   logic     ext_ok;

   always_comb begin
      ext_ok  = ext_edge & ~soft_start;
      src_d   = src_q;
      pulse_d = 1'b0;
      unique case (src_q)
         SRC_INT: begin
            pulse_d = tick | ext_ok;
            if (ext_ok) src_d = SRC_EXT;
         end
         SRC_EXT: begin
            if (soft_start) begin
               src_d   = SRC_INT;
               pulse_d = tick;
            end else begin
               pulse_d = ext_edge | expire;
               if (expire) src_d = SRC_INT;
            end
         end
         default: src_d = SRC_INT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= SRC_INT;
         pulse_q <= 1'b0;
      end else begin
         src_q   <= src_d;
         pulse_q <= pulse_d;
      end
   end

   assign src   = src_q;
   assign pulse = pulse_q;
endmodule

// File: rtl/clksel_top.sv
module clksel_top
   import clksel_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MISS_TICKS  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic int_tick,
   input  logic sync_in,
   input  logic soft_start,
   output logic cyc_start,
   output logic ext_active
);
   logic     ext_rise;
   logic     wd_expire;
   logic     wd_arm;
   clk_src_e cur_src;

   clksel_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sync_in),
      .rise (ext_rise)
   );

   assign wd_arm = (cur_src == SRC_EXT) & ~soft_start;

   clksel_miss_wdog #(.MISS_TICKS(MISS_TICKS)) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (wd_arm),
      .tick    (int_tick),
      .ext_edge(ext_rise),
      .expire  (wd_expire)
   );

   clksel_arbiter u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (int_tick),
      .ext_edge  (ext_rise),
      .soft_start(soft_start),
      .expire    (wd_expire),
      .src       (cur_src),
      .pulse     (cyc_start)
   );

   assign ext_active = (cur_src == SRC_EXT);
endmodule

// File: rtl/clksel_chk.sv
module clksel_chk (
   input logic clk,
   input logic rst_n,
   input logic int_tick,
   input logic soft_start,
   input logic ext_rise,
   input logic cyc_start,
   input logic ext_active
);
   // R1: outputs quiet in reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!cyc_start && !ext_active));

   // R2: internal tick paces a cycle one clock later
   p_int_pace_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (int_tick && !ext_active) |=> cyc_start);

   // R3: detected edge outside soft-start locks and starts a cycle
   p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_rise && !soft_start) |=> (ext_active && cyc_start));

   // R4: external mode stays silent with no edge and no tick
   p_ext_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_active && !ext_rise && !int_tick) |=> !cyc_start);

   // R5: fallback outside soft-start carries a cycle start
   p_fallback_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ext_active) && !$past(soft_start)) |-> cyc_start);

   // R7: soft-start keeps the internal source
   p_softstart_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
      soft_start |=> !ext_active);
endmodule

bind clksel_top clksel_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .int_tick  (int_tick),
   .soft_start(soft_start),
   .ext_rise  (ext_rise),
   .cyc_start (cyc_start),
   .ext_active(ext_active)
);

// File: tb/sim_clksel_top.sv
`timescale 1ns/1ps
module sim_clksel_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic int_tick = 1'b0;
   logic sync_in = 1'b0;
   logic soft_start = 1'b0;
   logic cyc_start;
   logic ext_active;

   int unsigned cyc = 0;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   typedef struct {
      int unsigned at;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   clksel_top u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .int_tick  (int_tick),
      .sync_in   (sync_in),
      .soft_start(soft_start),
      .cyc_start (cyc_start),
      .ext_active(ext_active)
   );

   task automatic push(int unsigned at, string tag);
      exp_t e;
      e.at  = at;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compare each cycle-start pulse against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
            checks++; fails++;
            $display("FAIL %s: missing cyc_start, actual none at %0d expected pulse at %0d",
                     exp_q[0].tag, cyc, exp_q[0].at);
            void'(exp_q.pop_front());
         end
         if (cyc_start) begin
            checks++;
            if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
               void'(exp_q.pop_front());
            end else begin
               fails++;
               $display("FAIL %s: unexpected cyc_start, actual 1 at %0d expected 0",
                        (exp_q.size() > 0) ? exp_q[0].tag : "R4", cyc);
            end
         end
      end
   end

   task automatic check_mode(bit exp, string tag);
      checks++;
      if (ext_active !== exp) begin
         fails++;
         $display("FAIL %s: ext_active actual %0b expected %0b at %0d", tag, ext_active, exp, cyc);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick(string tag, bit want);
      @(negedge clk);
      if (want) push(cyc + 1, tag);
      int_tick = 1'b1;
      @(negedge clk);
      int_tick = 1'b0;
   endtask

   task automatic sync_rise(string tag, bit want);
      @(negedge clk);
      if (want) push(cyc + 3, tag);
      sync_in = 1'b1;
      idle(3);
   endtask

   task automatic sync_fall();
      @(negedge clk);
      sync_in = 1'b0;
      idle(3);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      // R1: reset state
      idle(3);
      checks++;
      if (cyc_start !== 1'b0 || ext_active !== 1'b0) begin
         fails++;
         $display("FAIL R1: outputs actual %0b/%0b expected 0/0", cyc_start, ext_active);
      end
      @(negedge clk) rst_n = 1'b1;
      idle(3);
      check_mode(1'b0, "R1");

      // R2: internal pacing
      for (int i = 0; i < 3; i++) begin
         tick("R2", 1'b1);
         idle(4);
      end
      check_mode(1'b0, "R2");

      // R3: lock on first edge
      sync_rise("R3", 1'b1);
      check_mode(1'b1, "R3");
      sync_fall();

      // R6/R4: edges restart the missing-edge count, ticks are masked
      tick("R4", 1'b0);
      check_mode(1'b1, "R6");
      sync_rise("R4", 1'b1);
      sync_fall();
      tick("R6", 1'b0);
      check_mode(1'b1, "R6");
      idle(2);
      // R5: second tick without an edge falls back with a pulse
      tick("R5", 1'b1);
      check_mode(1'b0, "R5");
      tick("R5", 1'b1);
      check_mode(1'b0, "R5");

      // R9: held-high sync counts once
      sync_rise("R9", 1'b1);
      check_mode(1'b1, "R9");
      tick("R9", 1'b0);
      tick("R9", 1'b1);
      check_mode(1'b0, "R9");
      tick("R9", 1'b1);
      check_mode(1'b0, "R9");
      sync_fall();

      // R7: sync ignored during soft-start, ticks still pace
      @(negedge clk) soft_start = 1'b1;
      idle(2);
      sync_rise("R7", 1'b0);
      check_mode(1'b0, "R7");
      sync_fall();
      tick("R7", 1'b1);
      check_mode(1'b0, "R7");
      idle(2);
      @(negedge clk) soft_start = 1'b0;
      idle(2);
      sync_rise("R7", 1'b1);
      check_mode(1'b1, "R7");
      sync_fall();
      @(negedge clk) soft_start = 1'b1;
      @(negedge clk);
      check_mode(1'b0, "R7");
      @(negedge clk) soft_start = 1'b0;
      idle(3);

      // R8: simultaneous tick and edge give one pulse
      @(negedge clk);
      push(cyc + 3, "R8");
      sync_in = 1'b1;
      idle(2);
      int_tick = 1'b1;
      @(negedge clk);
      int_tick = 1'b0;
      check_mode(1'b1, "R8");
      idle(3);
      tick("R8", 1'b0);
      tick("R8", 1'b1);
      check_mode(1'b0, "R8");
      sync_fall();

      idle(10);
      while (exp_q.size() > 0) begin
         checks++; fails++;
         $display("FAIL %s: missing cyc_start, actual none expected pulse at %0d",
                  exp_q[0].tag, exp_q[0].at);
         void'(exp_q.pop_front());
      end
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run actual unfinished expected done");
         summary();
         $finish;
      end
   end
endmodule